// File: doc/BRIEF.md
# Dual-Issue In-Order Steering Unit

This block is the issue stage of a narrow in-order core. It holds a decode window of up to two instructions in program order. Each cycle it sends them to two execution pipes of different kinds. Loads and stores go to a memory pipe. Every other real instruction goes to an ALU/branch pipe. Two instructions of the same kind cannot leave together. An older instruction that cannot leave holds back the younger one, so the two always issue in program order.

A register read-after-write check gates each window entry. The check compares the entry's source registers against the destinations of the instructions still in flight, which the surrounding pipeline reports. A build-time option selects one of two interlock rules. Without forwarding, any in-flight writer of a source register stalls the reader. With forwarding, only a load that issued in the previous cycle stalls its reader, and then for one cycle.

The block reports how many window entries it consumed. Any entry left over moves to the older position, and the block takes up to as many fetch records as there are free slots. A one-wide build keeps a single-entry window and steers by kind in the same way.

Top module: `dual_issue_steer`

## Requirements
- R1: Type code 3 (load) and type code 4 (store) issue only on the memory pipe. Type codes 1, 2, 5, 6, 7 and 8 (register ALU, immediate ALU, branch, jump, system, register jump) issue only on the ALU pipe.
- R2: When both window entries need the same pipe, only the older entry issues and the other pipe stays idle. The younger entry issues in the next cycle, and `stall_young` is high in the blocked cycle.
- R3: If the older entry cannot issue, the younger entry does not issue either, even when its pipe is free. In that case `used_cnt` is 0.
- R4: `used_cnt` is 0, 1 or 2. An entry left over moves to the older slot. `take_cnt` equals the number of free slots, capped at the number of offered fetch records. Fetch record 0 always fills before fetch record 1.
- R5: Register index 255 (all ones) means "no register". It never forms a dependency, whether it appears as a source, as an in-flight destination or as a window destination.
- R6: With forwarding off, an entry stalls (`stall_old` for the older entry) while any in-flight destination matches one of its sources.
- R7: With forwarding on, a matching in-flight ALU producer causes no stall. A matching load producer stalls the reader only while that load is marked as being in its first stage after issue.
- R8: If the younger entry reads the older entry's destination, the younger entry does not issue in the same cycle. This holds in both forwarding modes.
- R9: An entry with type code 0 (no-op) is consumed without occupying either pipe, and it does not block a younger entry.
- R10: With `ISSUE_W`=1 the window holds one entry. `take_cnt` and `used_cnt` never exceed 1, and steering follows R1.
- R11: After reset the window is empty, both pipe outputs are invalid and `used_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fch_vld | input | 2 | Offered fetch records; bit 1 set only with bit 0 |
| fch_op | input | 2*4 | Type codes of fetch records 1 and 0 |
| fch_srca | input | 2*REG_W | First source register of each fetch record |
| fch_srcb | input | 2*REG_W | Second source register of each fetch record |
| fch_dst | input | 2*REG_W | Destination register of each fetch record |
| fly_dst | input | FLY_N*REG_W | Destinations of the instructions in flight |
| fly_load | input | FLY_N | In-flight entry is a load |
| fly_ex | input | FLY_N | In-flight entry is in its first stage after issue |
| take_cnt | output | 2 | Fetch records accepted this cycle |
| used_cnt | output | 2 | Window entries consumed this cycle |
| alu_vld | output | 1 | ALU pipe issue valid |
| alu_op | output | 4 | ALU pipe type code |
| alu_srca | output | REG_W | ALU pipe first source |
| alu_srcb | output | REG_W | ALU pipe second source |
| alu_dst | output | REG_W | ALU pipe destination |
| ls_vld | output | 1 | Memory pipe issue valid |
| ls_op | output | 4 | Memory pipe type code |
| ls_srca | output | REG_W | Memory pipe first source |
| ls_srcb | output | REG_W | Memory pipe second source |
| ls_dst | output | REG_W | Memory pipe destination |
| stall_old | output | 1 | Older entry held by a register interlock |
| stall_young | output | 1 | Younger entry present but not issued |

## Verification
The bench builds three copies side by side: two-wide without forwarding, two-wide with forwarding, and one-wide without forwarding. One table of window pairs and in-flight producers runs through both two-wide builds. The same stimulus therefore shows which interlocks the forwarding option removes (ALU producers, loads past their first stage) and which it keeps (a load in its first stage, dependencies inside one window group). The one-wide build covers the single-slot window, with its take and consume counts capped at one.

// File: rtl/dis_pkg.sv
package dis_pkg;

   localparam int OPW = 4;

   typedef enum logic [OPW-1:0] {
      OP_NONE   = 4'd0,
      OP_ALUR   = 4'd1,
      OP_ALUI   = 4'd2,
      OP_LOAD   = 4'd3,
      OP_STORE  = 4'd4,
      OP_BRANCH = 4'd5,
      OP_JUMP   = 4'd6,
      OP_SYS    = 4'd7,
      OP_JUMPR  = 4'd8
   } op_e;

   typedef enum logic [1:0] {
      LANE_NONE = 2'd0,
      LANE_ALU  = 2'd1,
      LANE_MEM  = 2'd2
   } lane_e;

   // kind of pipe an instruction needs; unknown codes and no-ops need none
   function automatic lane_e lane_of(input logic [OPW-1:0] op);
      case (op)
         OP_LOAD, OP_STORE:                                   return LANE_MEM;
         OP_ALUR, OP_ALUI, OP_BRANCH, OP_JUMP, OP_SYS, OP_JUMPR: return LANE_ALU;
         default:                                             return LANE_NONE;
      endcase
   endfunction

   function automatic logic [1:0] cnt2(input logic a, input logic b);
      return {1'b0, a} + {1'b0, b};
   endfunction

endpackage

// File: rtl/dis_raw_check.sv
module dis_raw_check #(
   parameter int REG_W  = 8,
   parameter int FLY_N  = 6,
   parameter bit FWD_EN = 1'b0
) (
   input  logic [REG_W-1:0]       src_a,
   input  logic [REG_W-1:0]       src_b,
   input  logic [FLY_N*REG_W-1:0] fly_dst,
   input  logic [FLY_N-1:0]       fly_load,
   input  logic [FLY_N-1:0]       fly_ex,
   output logic                   hit
);
   localparam logic [REG_W-1:0] NO_REG = {REG_W{1'b1}};

   logic [FLY_N-1:0] hit_v;

   generate
      for (genvar i = 0; i < FLY_N; i++) begin : g_fly
         logic [REG_W-1:0] d;
         logic             m;
         assign d = fly_dst[i*REG_W +: REG_W];
         // an absent destination can never pair with any source
         assign m = (d != NO_REG) && ((d == src_a) || (d == src_b));
         if (FWD_EN) begin : g_fwd
            // only a load one stage past issue cannot be bypassed yet
            assign hit_v[i] = m & fly_load[i] & fly_ex[i];
         end else begin : g_nofwd
            assign hit_v[i] = m;
         end
      end
   endgenerate

   assign hit = |hit_v;

endmodule

// File: rtl/dis_window.sv
module dis_window
   import dis_pkg::*;
#(
   parameter int REG_W   = 8,
   parameter int ISSUE_W = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [1:0]            used_cnt,
   input  logic [1:0]            fch_vld,
   input  logic [2*(OPW+3*REG_W)-1:0] fch_rec,
   output logic [1:0]            w_vld,
   output logic [2*(OPW+3*REG_W)-1:0] w_rec,
   output logic [1:0]            take_cnt
);
   localparam int RECW = OPW + 3*REG_W;

   logic [1:0]            vld_q;
   logic [1:0][RECW-1:0]  rec_q;
   logic [1:0]            nxt_vld;
   logic [1:0][RECW-1:0]  nxt_rec;
   logic [RECW-1:0]       f0;
   logic [RECW-1:0]       f1;

   assign f0 = fch_rec[RECW-1:0];
   assign f1 = fch_rec[2*RECW-1:RECW];

   generate
      if (ISSUE_W == 2) begin : g_two
         logic [1:0]           kv;
         logic [RECW-1:0]      k0;
         logic [RECW-1:0]      k1;
         logic [1:0]           keep;
         logic [1:0]           free;
         logic [1:0]           offered;
         logic [1:0]           take;

         always_comb begin
            kv = 2'b00;
            k0 = '0;
            k1 = '0;
            case (used_cnt)
               2'd0: begin
                  kv = vld_q;
                  k0 = rec_q[0];
                  k1 = rec_q[1];
               end
               2'd1: begin
                  kv = {1'b0, vld_q[1]};
                  k0 = rec_q[1];
               end
               default: ;
            endcase
            keep    = cnt2(kv[0], kv[1]);
            free    = 2'd2 - keep;
            offered = fch_vld[0] ? (fch_vld[1] ? 2'd2 : 2'd1) : 2'd0;
            take    = (free < offered) ? free : offered;

            nxt_vld    = kv;
            nxt_rec[0] = k0;
            nxt_rec[1] = k1;
            if (!kv[0]) begin
               if (take != 2'd0) begin
                  nxt_vld[0] = 1'b1;
                  nxt_rec[0] = f0;
               end
               if (take == 2'd2) begin
                  nxt_vld[1] = 1'b1;
                  nxt_rec[1] = f1;
               end
            end else if (!kv[1] && take != 2'd0) begin
               nxt_vld[1] = 1'b1;
               nxt_rec[1] = f0;
            end
            take_cnt = take;
         end
      end else begin : g_one
         logic kv0;
         logic take1;
         logic unused_w1;

         assign unused_w1 = ^{fch_vld[1], f1, vld_q[1], rec_q[1]};

         always_comb begin
            kv0        = vld_q[0] && (used_cnt == 2'd0);
            take1      = !kv0 && fch_vld[0];
            nxt_vld    = {1'b0, kv0 | take1};
            nxt_rec[0] = kv0 ? rec_q[0] : f0;
            nxt_rec[1] = '0;
            take_cnt   = {1'b0, take1};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 2'b00;
         rec_q <= '0;
      end else begin
         vld_q <= nxt_vld;
         rec_q <= nxt_rec;
      end
   end

   assign w_vld = vld_q;
   assign w_rec = rec_q;

endmodule

// File: rtl/dis_pick.sv
module dis_pick
   import dis_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic [1:0]                 w_vld,
   input  logic [2*(OPW+3*REG_W)-1:0] w_rec,
   input  logic                       haz0,
   input  logic                       haz1,
   output logic                       alu_vld,
   output logic [OPW+3*REG_W-1:0]     alu_rec,
   output logic                       ls_vld,
   output logic [OPW+3*REG_W-1:0]     ls_rec,
   output logic [1:0]                 used_cnt,
   output logic                       stall_old,
   output logic                       stall_young
);
   localparam int RECW = OPW + 3*REG_W;
   localparam logic [REG_W-1:0] NO_REG = {REG_W{1'b1}};

   logic [RECW-1:0]  r0;
   logic [RECW-1:0]  r1;
   lane_e            ln0;
   lane_e            ln1;
   logic [REG_W-1:0] d0;
   logic [REG_W-1:0] a1;
   logic [REG_W-1:0] b1;
   logic             go0;
   logic             go1;
   logic             dep;
   logic             clash;

   assign r0  = w_rec[RECW-1:0];
   assign r1  = w_rec[2*RECW-1:RECW];
   assign ln0 = lane_of(r0[RECW-1 -: OPW]);
   assign ln1 = lane_of(r1[RECW-1 -: OPW]);
   assign d0  = r0[REG_W-1:0];
   assign a1  = r1[3*REG_W-1 -: REG_W];
   assign b1  = r1[2*REG_W-1 -: REG_W];

   // the younger reads what the older writes: never in the same cycle
   assign dep   = (d0 != NO_REG) && ((a1 == d0) || (b1 == d0));
   assign clash = (ln0 != LANE_NONE) && (ln0 == ln1);
   assign go0   = w_vld[0] & ~haz0;
   assign go1   = w_vld[1] & go0 & ~haz1 & ~dep & ~clash;

   always_comb begin
      alu_vld = 1'b0;
      alu_rec = '0;
      ls_vld  = 1'b0;
      ls_rec  = '0;
      if (go0 && ln0 == LANE_ALU) begin
         alu_vld = 1'b1;
         alu_rec = r0;
      end else if (go1 && ln1 == LANE_ALU) begin
         alu_vld = 1'b1;
         alu_rec = r1;
      end
      if (go0 && ln0 == LANE_MEM) begin
         ls_vld = 1'b1;
         ls_rec = r0;
      end else if (go1 && ln1 == LANE_MEM) begin
         ls_vld = 1'b1;
         ls_rec = r1;
      end
   end

   assign used_cnt    = cnt2(go0, go1);
   assign stall_old   = w_vld[0] & haz0;
   assign stall_young = w_vld[1] & ~go1;

endmodule

// File: rtl/dual_issue_steer.sv
module dual_issue_steer
   import dis_pkg::*;
#(
   parameter int REG_W   = 8,
   parameter int FLY_N   = 6,
   parameter int ISSUE_W = 2,
   parameter bit FWD_EN  = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [1:0]             fch_vld,
   input  logic [2*OPW-1:0]       fch_op,
   input  logic [2*REG_W-1:0]     fch_srca,
   input  logic [2*REG_W-1:0]     fch_srcb,
   input  logic [2*REG_W-1:0]     fch_dst,
   input  logic [FLY_N*REG_W-1:0] fly_dst,
   input  logic [FLY_N-1:0]       fly_load,
   input  logic [FLY_N-1:0]       fly_ex,
   output logic [1:0]             take_cnt,
   output logic [1:0]             used_cnt,
   output logic                   alu_vld,
   output logic [OPW-1:0]         alu_op,
   output logic [REG_W-1:0]       alu_srca,
   output logic [REG_W-1:0]       alu_srcb,
   output logic [REG_W-1:0]       alu_dst,
   output logic                   ls_vld,
   output logic [OPW-1:0]         ls_op,
   output logic [REG_W-1:0]       ls_srca,
   output logic [REG_W-1:0]       ls_srcb,
   output logic [REG_W-1:0]       ls_dst,
   output logic                   stall_old,
   output logic                   stall_young
);
   localparam int RECW = OPW + 3*REG_W;

   generate
      if (!(ISSUE_W == 1 || ISSUE_W == 2)) begin : g_bad_width
         $error("dual_issue_steer: ISSUE_W must be 1 or 2");
      end
      if (REG_W < 2) begin : g_bad_reg
         $error("dual_issue_steer: REG_W must be at least 2");
      end
      if (FLY_N < 1) begin : g_bad_fly
         $error("dual_issue_steer: FLY_N must be at least 1");
      end
   endgenerate

   logic [2*RECW-1:0] fch_rec;
   logic [2*RECW-1:0] w_rec;
   logic [1:0]        w_vld;
   logic [1:0]        haz;
   logic [RECW-1:0]   alu_rec;
   logic [RECW-1:0]   ls_rec;

   generate
      for (genvar k = 0; k < 2; k++) begin : g_slot
         logic [RECW-1:0] wr;
         assign fch_rec[k*RECW +: RECW] = {fch_op[k*OPW +: OPW],
                                           fch_srca[k*REG_W +: REG_W],
                                           fch_srcb[k*REG_W +: REG_W],
                                           fch_dst[k*REG_W +: REG_W]};
         assign wr = w_rec[k*RECW +: RECW];

         dis_raw_check #(
            .REG_W  (REG_W),
            .FLY_N  (FLY_N),
            .FWD_EN (FWD_EN)
         ) u_raw (
            .src_a    (wr[3*REG_W-1 -: REG_W]),
            .src_b    (wr[2*REG_W-1 -: REG_W]),
            .fly_dst  (fly_dst),
            .fly_load (fly_load),
            .fly_ex   (fly_ex),
            .hit      (haz[k])
         );
      end
   endgenerate

   dis_window #(
      .REG_W   (REG_W),
      .ISSUE_W (ISSUE_W)
   ) u_win (
      .clk      (clk),
      .rst      (rst),
      .used_cnt (used_cnt),
      .fch_vld  (fch_vld),
      .fch_rec  (fch_rec),
      .w_vld    (w_vld),
      .w_rec    (w_rec),
      .take_cnt (take_cnt)
   );

   dis_pick #(
      .REG_W (REG_W)
   ) u_pick (
      .w_vld       (w_vld),
      .w_rec       (w_rec),
      .haz0        (haz[0]),
      .haz1        (haz[1]),
      .alu_vld     (alu_vld),
      .alu_rec     (alu_rec),
      .ls_vld      (ls_vld),
      .ls_rec      (ls_rec),
      .used_cnt    (used_cnt),
      .stall_old   (stall_old),
      .stall_young (stall_young)
   );

   assign {alu_op, alu_srca, alu_srcb, alu_dst} = alu_rec;
   assign {ls_op, ls_srca, ls_srcb, ls_dst}     = ls_rec;

endmodule

// File: rtl/dual_issue_steer_chk.sv
module dual_issue_steer_chk #(
   parameter int ISSUE_W = 2
) (
   input logic       clk,
   input logic       rst,
   input logic [1:0] fch_vld,
   input logic [1:0] take_cnt,
   input logic [1:0] used_cnt,
   input logic       alu_vld,
   input logic [3:0] alu_op,
   input logic       ls_vld,
   input logic [3:0] ls_op,
   input logic       stall_old
);
   // R1: ALU pipe never carries memory ops or no-ops
   a_r1_alu_kind: assert property (@(posedge clk) disable iff (rst)
      alu_vld |-> (alu_op == 4'd1 || alu_op == 4'd2 || alu_op == 4'd5 ||
                   alu_op == 4'd6 || alu_op == 4'd7 || alu_op == 4'd8));

   // R1: memory pipe carries only loads and stores
   a_r1_ls_kind: assert property (@(posedge clk) disable iff (rst)
      ls_vld |-> (ls_op == 4'd3 || ls_op == 4'd4));

   // R3: a held older entry holds everything
   a_r3_old_blocks_all: assert property (@(posedge clk) disable iff (rst)
      stall_old |-> (used_cnt == 2'd0 && !alu_vld && !ls_vld));

   // R4: every issued pipe is counted as consumed
   a_r4_used_covers_issue: assert property (@(posedge clk) disable iff (rst)
      ($countones({alu_vld, ls_vld}) <= used_cnt) && (used_cnt != 2'd3));

   // R4: never take more than is offered
   a_r4_take_le_offer: assert property (@(posedge clk) disable iff (rst)
      take_cnt <= 2'($countones(fch_vld)));

   // R11: the first cycle out of reset issues nothing
   a_r11_reset_empty: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!alu_vld && !ls_vld && used_cnt == 2'd0));

   generate
      if (ISSUE_W == 1) begin : g_one
         // R10: single-slot build moves at most one entry each way
         a_r10_one_wide: assert property (@(posedge clk) disable iff (rst)
            (used_cnt <= 2'd1) && (take_cnt <= 2'd1));
      end
   endgenerate

endmodule

bind dual_issue_steer dual_issue_steer_chk #(.ISSUE_W(ISSUE_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .fch_vld   (fch_vld),
   .take_cnt  (take_cnt),
   .used_cnt  (used_cnt),
   .alu_vld   (alu_vld),
   .alu_op    (alu_op),
   .ls_vld    (ls_vld),
   .ls_op     (ls_op),
   .stall_old (stall_old)
);

// File: tb/dual_issue_steer_tb_top.sv
`timescale 1ns/1ps
module dual_issue_steer_tb_top;
   localparam int NF = 6;
   localparam logic [7:0] X = 8'hFF;

   typedef struct packed {
      logic [3:0] op0; logic [7:0] a0; logic [7:0] b0; logic [7:0] d0;
      logic [3:0] op1; logic [7:0] a1; logic [7:0] b1; logic [7:0] d1;
      logic [7:0] fd;  logic fl; logic fe;
      logic [1:0] n_alu; logic [1:0] n_ls; logic [1:0] n_used;
      logic [1:0] f_alu; logic [1:0] f_ls; logic [1:0] f_used;
   } vec_t;

   // sel: 0 idle, 1 older entry, 2 younger entry
   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{4'd1, 8'd1, 8'd2, 8'd10, 4'd3, 8'd3, X, 8'd11, X, 1'b0, 1'b0, 2'd1, 2'd2, 2'd2, 2'd1, 2'd2, 2'd2}, // R1 both pipes
      '{4'd2, 8'd1, X, 8'd10, 4'd2, 8'd3, X, 8'd11, X, 1'b0, 1'b0, 2'd1, 2'd0, 2'd1, 2'd1, 2'd0, 2'd1},     // R2 alu clash
      '{4'd4, 8'd1, 8'd2, X, 4'd3, 8'd3, X, 8'd11, X, 1'b0, 1'b0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd1, 2'd1},      // R2 mem clash
      '{4'd3, 8'd1, X, 8'd10, 4'd1, 8'd10, 8'd2, 8'd11, X, 1'b0, 1'b0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd1, 2'd1}, // R8 load->alu in group
      '{4'd1, 8'd1, 8'd2, 8'd10, 4'd4, 8'd3, 8'd10, X, X, 1'b0, 1'b0, 2'd1, 2'd0, 2'd1, 2'd1, 2'd0, 2'd1},  // R8 alu->store in group
      '{4'd1, 8'd5, 8'd2, 8'd10, 4'd3, 8'd3, X, 8'd11, 8'd5, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd2}, // R6 R7 alu producer
      '{4'd1, 8'd5, 8'd2, 8'd10, 4'd3, 8'd3, X, 8'd11, 8'd5, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0}, // R3 R7 fresh load
      '{4'd1, 8'd5, 8'd2, 8'd10, 4'd3, 8'd3, X, 8'd11, 8'd5, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd2}, // R7 older load
      '{4'd5, X, X, X, 4'd3, X, X, 8'd11, X, 1'b0, 1'b1, 2'd1, 2'd2, 2'd2, 2'd1, 2'd2, 2'd2},              // R5 reg 255
      '{4'd0, X, X, X, 4'd3, 8'd3, X, 8'd11, X, 1'b0, 1'b0, 2'd0, 2'd2, 2'd2, 2'd0, 2'd2, 2'd2},            // R9 no-op drain
      '{4'd8, 8'd4, X, X, 4'd7, 8'd5, X, 8'd11, X, 1'b0, 1'b0, 2'd1, 2'd0, 2'd1, 2'd1, 2'd0, 2'd1},         // R1 jreg/sys
      '{4'd6, X, X, 8'd31, 4'd4, 8'd3, 8'd4, X, X, 1'b0, 1'b0, 2'd1, 2'd2, 2'd2, 2'd1, 2'd2, 2'd2},         // R1 jump/store
      '{4'd1, 8'd1, 8'd2, 8'd10, 4'd3, 8'd6, X, 8'd11, 8'd6, 1'b0, 1'b1, 2'd1, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2} // R6 R7 younger vs flight
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [1:0]      fch_vld = 2'b00;
   logic [7:0]      fch_op = '0;
   logic [15:0]     fch_srca = '0, fch_srcb = '0, fch_dst = '0;
   logic [NF*8-1:0] fly_dst = {NF{8'hFF}};
   logic [NF-1:0]   fly_load = '0, fly_ex = '0;

   logic [1:0] take_i, used_i, take_f, used_f, take_n, used_n;
   logic       alu_v_i, ls_v_i, so_i, sy_i, alu_v_f, ls_v_f, so_f, sy_f, alu_v_n, ls_v_n, so_n, sy_n;
   logic [3:0] alu_o_i, ls_o_i, alu_o_f, ls_o_f, alu_o_n, ls_o_n;
   logic [7:0] alu_a_i, alu_b_i, alu_d_i, ls_a_i, ls_b_i, ls_d_i;
   logic [7:0] alu_a_f, alu_b_f, alu_d_f, ls_a_f, ls_b_f, ls_d_f;
   logic [7:0] alu_a_n, alu_b_n, alu_d_n, ls_a_n, ls_b_n, ls_d_n;

   dual_issue_steer #(.REG_W(8), .FLY_N(NF), .ISSUE_W(2), .FWD_EN(1'b0)) dut_i (
      .clk(clk), .rst(rst), .fch_vld(fch_vld), .fch_op(fch_op), .fch_srca(fch_srca),
      .fch_srcb(fch_srcb), .fch_dst(fch_dst), .fly_dst(fly_dst), .fly_load(fly_load),
      .fly_ex(fly_ex), .take_cnt(take_i), .used_cnt(used_i), .alu_vld(alu_v_i),
      .alu_op(alu_o_i), .alu_srca(alu_a_i), .alu_srcb(alu_b_i), .alu_dst(alu_d_i),
      .ls_vld(ls_v_i), .ls_op(ls_o_i), .ls_srca(ls_a_i), .ls_srcb(ls_b_i), .ls_dst(ls_d_i),
      .stall_old(so_i), .stall_young(sy_i));

   dual_issue_steer #(.REG_W(8), .FLY_N(NF), .ISSUE_W(2), .FWD_EN(1'b1)) dut_f (
      .clk(clk), .rst(rst), .fch_vld(fch_vld), .fch_op(fch_op), .fch_srca(fch_srca),
      .fch_srcb(fch_srcb), .fch_dst(fch_dst), .fly_dst(fly_dst), .fly_load(fly_load),
      .fly_ex(fly_ex), .take_cnt(take_f), .used_cnt(used_f), .alu_vld(alu_v_f),
      .alu_op(alu_o_f), .alu_srca(alu_a_f), .alu_srcb(alu_b_f), .alu_dst(alu_d_f),
      .ls_vld(ls_v_f), .ls_op(ls_o_f), .ls_srca(ls_a_f), .ls_srcb(ls_b_f), .ls_dst(ls_d_f),
      .stall_old(so_f), .stall_young(sy_f));

   dual_issue_steer #(.REG_W(8), .FLY_N(NF), .ISSUE_W(1), .FWD_EN(1'b0)) dut_n (
      .clk(clk), .rst(rst), .fch_vld(fch_vld), .fch_op(fch_op), .fch_srca(fch_srca),
      .fch_srcb(fch_srcb), .fch_dst(fch_dst), .fly_dst(fly_dst), .fly_load(fly_load),
      .fly_ex(fly_ex), .take_cnt(take_n), .used_cnt(used_n), .alu_vld(alu_v_n),
      .alu_op(alu_o_n), .alu_srca(alu_a_n), .alu_srcb(alu_b_n), .alu_dst(alu_d_n),
      .ls_vld(ls_v_n), .ls_op(ls_o_n), .ls_srca(ls_a_n), .ls_srcb(ls_b_n), .ls_dst(ls_d_n),
      .stall_old(so_n), .stall_young(sy_n));

   int errs = 0;
   int total = 0;

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_fetch(input logic [1:0] v,
                            input logic [3:0] o0, input logic [7:0] a0, input logic [7:0] b0, input logic [7:0] d0,
                            input logic [3:0] o1, input logic [7:0] a1, input logic [7:0] b1, input logic [7:0] d1);
      fch_vld  = v;
      fch_op   = {o1, o0};
      fch_srca = {a1, a0};
      fch_srcb = {b1, b0};
      fch_dst  = {d1, d0};
   endtask

   task automatic set_fly(input logic [7:0] d, input logic l, input logic e);
      fly_dst  = {{(NF-1){8'hFF}}, d};
      fly_load = {{(NF-1){1'b0}}, l};
      fly_ex   = {{(NF-1){1'b0}}, e};
   endtask

   task automatic do_reset();
      rst = 1'b1;
      fch_vld = 2'b00;
      set_fly(X, 1'b0, 1'b0);
      tick();
      tick();
      rst = 1'b0;
   endtask

   function automatic logic [31:0] exp_t(input logic [1:0] sel, input vec_t v);
      case (sel)
         2'd1:    return {15'd0, 1'b1, v.a0, v.d0};
         2'd2:    return {15'd0, 1'b1, v.a1, v.d1};
         default: return 32'd0;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      total++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errs, total);
      $finish;
   end

   initial begin
      // R11: reset state, with fetch records offered during reset
      rst = 1'b1;
      set_fetch(2'b11, 4'd1, 8'd1, 8'd2, 8'd10, 4'd3, 8'd3, X, 8'd11);
      tick();
      tick();
      #1;
      check("R11 reset alu_vld", alu_v_i, 0);
      check("R11 reset ls_vld", ls_v_i, 0);
      check("R11 reset used_cnt", used_i, 0);
      do_reset();
      #1;
      check("R11 after reset empty", {alu_v_i, ls_v_i, used_i, alu_v_n, ls_v_n}, 0);

      // table walk over both two-wide builds (R1 R2 R3 R5 R6 R7 R8 R9)
      for (int v = 0; v < NV; v++) begin
         do_reset();
         set_fetch(2'b11, VEC[v].op0, VEC[v].a0, VEC[v].b0, VEC[v].d0,
                   VEC[v].op1, VEC[v].a1, VEC[v].b1, VEC[v].d1);
         tick();
         fch_vld = 2'b00;
         set_fly(VEC[v].fd, VEC[v].fl, VEC[v].fe);
         #1;
         check($sformatf("table %0d alu nofwd", v), {15'd0, alu_v_i, alu_a_i, alu_d_i}, exp_t(VEC[v].n_alu, VEC[v]));
         check($sformatf("table %0d mem nofwd", v), {15'd0, ls_v_i, ls_a_i, ls_d_i}, exp_t(VEC[v].n_ls, VEC[v]));
         check($sformatf("table %0d used nofwd", v), used_i, VEC[v].n_used);
         check($sformatf("table %0d alu fwd", v), {15'd0, alu_v_f, alu_a_f, alu_d_f}, exp_t(VEC[v].f_alu, VEC[v]));
         check($sformatf("table %0d mem fwd", v), {15'd0, ls_v_f, ls_a_f, ls_d_f}, exp_t(VEC[v].f_ls, VEC[v]));
         check($sformatf("table %0d used fwd", v), used_f, VEC[v].f_used);
      end

      // R2 R4: clash, then younger issues next cycle; refill takes record 0 only
      do_reset();
      set_fetch(2'b11, 4'd2, 8'd1, X, 8'd10, 4'd2, 8'd3, X, 8'd11);
      tick();
      set_fetch(2'b11, 4'd3, 8'd20, X, 8'd20, 4'd1, 8'd21, 8'd22, 8'd21);
      #1;
      check("R2 stall_young on clash", sy_i, 1);
      check("R4 take_cnt one free slot", take_i, 1);
      tick();
      fch_vld = 2'b00;
      set_fly(8'd10, 1'b0, 1'b1);
      #1;
      check("R2 younger issues next cycle", {alu_v_i, alu_d_i}, {1'b1, 8'd11});
      check("R4 fetch record 0 filled behind", {ls_v_i, ls_d_i}, {1'b1, 8'd20});
      check("R4 used two", used_i, 2);

      // R3 R6: older held, window full, nothing taken
      do_reset();
      set_fetch(2'b11, 4'd1, 8'd5, 8'd2, 8'd10, 4'd3, 8'd3, X, 8'd11);
      tick();
      set_fly(8'd5, 1'b0, 1'b1);
      #1;
      check("R6 stall_old nofwd", so_i, 1);
      check("R3 younger held too", sy_i, 1);
      check("R4 take_cnt zero when full", take_i, 0);
      check("R7 no stall with fwd", {so_f, used_f}, {1'b0, 2'd2});

      // R10: one-wide build takes one per cycle and steers by kind
      do_reset();
      set_fetch(2'b11, 4'd1, 8'd1, 8'd2, 8'd10, 4'd3, 8'd3, X, 8'd11);
      #1;
      check("R10 take one when empty", take_n, 1);
      tick();
      set_fetch(2'b01, 4'd3, 8'd3, X, 8'd11, 4'd0, X, X, X);
      #1;
      check("R10 alu issue", {alu_v_n, alu_d_n, ls_v_n}, {1'b1, 8'd10, 1'b0});
      check("R10 used and take", {used_n, take_n}, {2'd1, 2'd1});
      tick();
      fch_vld = 2'b00;
      #1;
      check("R10 load on memory pipe", {ls_v_n, ls_d_n, alu_v_n}, {1'b1, 8'd11, 1'b0});

      $display("  Result: errors=%0d of %0d checks", errs, total);
      $finish;
   end

endmodule